// File: doc/BRIEF.md
# Programmable PI Timing Loop Filter

This block is the loop filter of a symbol timing recovery loop. On every cycle with its valid strobe high it takes a signed timing error sample and forms two terms. The proportional term is the error times an 8-bit unsigned gain, shifted right by a fixed four bits. The integral term comes from an integrator. The integrator adds the error, scaled by a gain given as a 5-bit mantissa and a 3-bit exponent, and it saturates to a signed width picked from eight settings. The sum of the two terms, saturated to 16 bits, is registered and drives the frequency control input of a timing NCO.

A controller can read the eight most significant bits of the integrator's selected width at any time. It can also load those bits, and the load zeroes every bit below them. A separate synchronous clear input zeroes the whole integrator. This input is meant for an external state machine that detects an integrator stuck in saturation after a signal drop-out.

Top module: `timing_pi_filter`

## Requirements
- R1: After reset, `ctrl_out` is 0 and `int_rdata` is 0.
- R2: One cycle after a valid sample `e` with gain `alpha`, the proportional contribution to `ctrl_out` is floor(e*alpha/16), with `alpha` read as unsigned 0..255.
- R3: On a valid cycle the integrator adds e*m*2^x, where m = `beta_code[4:0]` (unsigned) and x = `beta_code[7:5]`. On the next cycle `ctrl_out` equals the saturated sum of the proportional term and the updated integrator value.
- R4: `lim_sel` codes 0..7 select integrator widths 8, 10, 12, 14, 16, 17, 18 and 20 bits. An accumulation result outside the signed range of width W is clamped to -2^(W-1) or 2^(W-1)-1 and does not wrap.
- R5: `int_rdata` always shows integrator bits [W-1:W-8] for the current width W. At positive saturation it reads 0x7F, and at negative saturation it reads 0x80.
- R6: A write (`int_wr`=1) sets the integrator to sign-extended `int_wdata` times 2^(W-8), so all lower bits are zero. A write takes priority over accumulation in the same cycle, and if that cycle is valid the output uses the written value.
- R7: `int_clear`=1 zeroes the whole integrator on the next edge. It takes priority over a write and over accumulation in the same cycle.
- R8: On cycles with `err_valid`=0 and no clear or write, the integrator and `ctrl_out` keep their values, even when the error, gains or limiter code change.
- R9: `ctrl_out` saturates to the 16-bit signed range: 32767 for large positive sums and -32768 for large negative sums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Error sample valid strobe |
| err_in | input | 12 | Signed timing error sample |
| alpha | input | 8 | Unsigned proportional gain |
| beta_code | input | 8 | Integral gain code: exponent [7:5], mantissa [4:0] |
| lim_sel | input | 3 | Integrator width select |
| int_clear | input | 1 | Synchronous integrator clear |
| int_wr | input | 1 | Load strobe for the integrator's top byte |
| int_wdata | input | 8 | Value for the integrator's top byte |
| int_rdata | output | 8 | Top byte of the integrator within the selected width |
| ctrl_out | output | 16 | Registered signed NCO control word |

## Verification
The bench sweeps the gains and error extremes, including the full-scale negative error times gain 255, where a wrong sign extension of the unsigned gain would turn the product's sign around. It drives the integrator into both rails at every width code, where a wrapping adder would swing to the opposite rail and a wrong width table would give a read byte other than 0x7F or 0x80. It loads the top byte at every width and then accumulates a small step, which exposes any leftover low bits. It also puts clear, write and a valid sample in the same cycle, so a wrong priority order shows up as a non-zero integrator or a wrong output.

// File: rtl/timing_pi_pkg.sv
package timing_pi_pkg;
  localparam int SEL_W = 3;

  function automatic int lim_width(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: lim_width = 8;
      3'd1: lim_width = 10;
      3'd2: lim_width = 12;
      3'd3: lim_width = 14;
      3'd4: lim_width = 16;
      3'd5: lim_width = 17;
      3'd6: lim_width = 18;
      default: lim_width = 20;
    endcase
  endfunction
endpackage

// File: rtl/pi_prop_path.sv
module pi_prop_path #(
  parameter int ERR_W = 12,
  parameter int GAIN_W = 8,
  parameter int SHIFT = 4,
  localparam int PROD_W = ERR_W + GAIN_W + 1
) (
  input  logic signed [ERR_W-1:0]  err_in,
  input  logic [GAIN_W-1:0]        alpha,
  output logic signed [PROD_W-1:0] prop
);
  logic signed [PROD_W-1:0] product;

  always_comb begin
    product = err_in * $signed({1'b0, alpha});
    prop    = product >>> SHIFT;
  end
endmodule

// File: rtl/pi_integrator.sv
module pi_integrator
  import timing_pi_pkg::*;
#(
  parameter int ERR_W = 12,
  parameter int MANT_W = 5,
  parameter int EXP_W = 3,
  parameter int INT_W = 24,
  parameter int RD_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      err_valid,
  input  logic signed [ERR_W-1:0]   err_in,
  input  logic [MANT_W+EXP_W-1:0]   beta_code,
  input  logic [SEL_W-1:0]          lim_sel,
  input  logic                      int_clear,
  input  logic                      int_wr,
  input  logic [RD_W-1:0]           int_wdata,
  output logic signed [INT_W-1:0]   acc_next,
  output logic signed [INT_W-1:0]   acc_q,
  output logic [RD_W-1:0]           int_rdata
);
  localparam int SCL_W = ERR_W + MANT_W + 1;
  localparam int INC_W = SCL_W + (2**EXP_W - 1);
  localparam int SUM_W = ((INT_W > INC_W) ? INT_W : INC_W) + 1;

  logic [MANT_W-1:0]        mant;
  logic [EXP_W-1:0]         expo;
  logic signed [SCL_W-1:0]  scaled;
  logic signed [INC_W-1:0]  inc;
  logic signed [SUM_W-1:0]  sum, hi, lo, clipped;
  logic signed [INT_W-1:0]  wval, rd_shift;
  int                       w;

  always_comb begin
    mant    = beta_code[MANT_W-1:0];
    expo    = beta_code[MANT_W+EXP_W-1 -: EXP_W];
    w       = lim_width(lim_sel);
    scaled  = err_in * $signed({1'b0, mant});
    inc     = INC_W'(scaled) <<< expo;
    sum     = SUM_W'(acc_q) + SUM_W'(inc);
    hi      = (SUM_W'(1) <<< (w - 1)) - SUM_W'(1);
    lo      = ~hi;
    if (sum > hi)      clipped = hi;
    else if (sum < lo) clipped = lo;
    else               clipped = sum;
    wval    = INT_W'($signed(int_wdata)) <<< (w - RD_W);

    if (int_clear)      acc_next = '0;
    else if (int_wr)    acc_next = wval;
    else if (err_valid) acc_next = INT_W'(clipped);
    else                acc_next = acc_q;

    rd_shift  = acc_q >>> (w - RD_W);
    int_rdata = rd_shift[RD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_next;
  end
endmodule

// File: rtl/pi_out_stage.sv
module pi_out_stage #(
  parameter int INT_W = 24,
  parameter int PROD_W = 21,
  parameter int OUT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     err_valid,
  input  logic signed [INT_W-1:0]  acc_next,
  input  logic signed [PROD_W-1:0] prop,
  output logic signed [OUT_W-1:0]  ctrl_out
);
  localparam int OSUM_W = ((INT_W > PROD_W) ? INT_W : PROD_W) + 1;
  localparam logic signed [OSUM_W-1:0] OHI = OSUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [OSUM_W-1:0] OLO = ~OHI;

  logic signed [OSUM_W-1:0] total;
  logic signed [OUT_W-1:0]  clipped;

  always_comb begin
    total = OSUM_W'(acc_next) + OSUM_W'(prop);
    if (total > OHI)      clipped = OUT_W'(OHI);
    else if (total < OLO) clipped = OUT_W'(OLO);
    else                  clipped = OUT_W'(total);
  end

  always_ff @(posedge clk) begin
    if (rst)            ctrl_out <= '0;
    else if (err_valid) ctrl_out <= clipped;
  end
endmodule

// File: rtl/timing_pi_filter.sv
module timing_pi_filter
  import timing_pi_pkg::*;
#(
  parameter int ERR_W = 12,
  parameter int GAIN_W = 8,
  parameter int MANT_W = 5,
  parameter int INT_W = 24,
  parameter int OUT_W = 16,
  parameter int PROP_SHIFT = 4,
  parameter int RD_W = 8,
  localparam int EXP_W = GAIN_W - MANT_W,
  localparam int PROD_W = ERR_W + GAIN_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     err_valid,
  input  logic signed [ERR_W-1:0]  err_in,
  input  logic [GAIN_W-1:0]        alpha,
  input  logic [GAIN_W-1:0]        beta_code,
  input  logic [SEL_W-1:0]         lim_sel,
  input  logic                     int_clear,
  input  logic                     int_wr,
  input  logic [RD_W-1:0]          int_wdata,
  output logic [RD_W-1:0]          int_rdata,
  output logic signed [OUT_W-1:0]  ctrl_out
);
  logic signed [PROD_W-1:0] prop;
  logic signed [INT_W-1:0]  acc_next;
  logic signed [INT_W-1:0]  int_value;

  pi_prop_path #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .SHIFT(PROP_SHIFT)) u_prop (
    .err_in(err_in), .alpha(alpha), .prop(prop)
  );

  pi_integrator #(.ERR_W(ERR_W), .MANT_W(MANT_W), .EXP_W(EXP_W),
                  .INT_W(INT_W), .RD_W(RD_W)) u_int (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_in(err_in),
    .beta_code(beta_code), .lim_sel(lim_sel), .int_clear(int_clear),
    .int_wr(int_wr), .int_wdata(int_wdata), .acc_next(acc_next),
    .acc_q(int_value), .int_rdata(int_rdata)
  );

  pi_out_stage #(.INT_W(INT_W), .PROD_W(PROD_W), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .err_valid(err_valid), .acc_next(acc_next),
    .prop(prop), .ctrl_out(ctrl_out)
  );
endmodule

// File: rtl/timing_pi_checker.sv
module timing_pi_checker
  import timing_pi_pkg::*;
#(
  parameter int INT_W = 24,
  parameter int OUT_W = 16,
  parameter int RD_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    err_valid,
  input logic                    int_clear,
  input logic                    int_wr,
  input logic [RD_W-1:0]         int_wdata,
  input logic [SEL_W-1:0]        lim_sel,
  input logic [RD_W-1:0]         int_rdata,
  input logic signed [OUT_W-1:0] ctrl_out,
  input logic signed [INT_W-1:0] int_value
);
  logic [SEL_W-1:0]        sel_d;
  logic signed [INT_W-1:0] hi_d, lo_d;

  always_ff @(posedge clk) sel_d <= lim_sel;

  always_comb begin
    hi_d = (INT_W'(1) <<< (lim_width(sel_d) - 1)) - INT_W'(1);
    lo_d = ~hi_d;
  end

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
    int_clear |=> (int_value == '0) && (int_rdata == '0));

  assert_write_load_R6: assert property (@(posedge clk) disable iff (rst)
    (int_wr && !int_clear) |=> ((lim_sel != $past(lim_sel)) || (int_rdata == $past(int_wdata))));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!err_valid && !int_clear && !int_wr) |=> ($stable(int_value) && $stable(ctrl_out)));

  assert_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !int_clear && !int_wr) |=> ((int_value <= hi_d) && (int_value >= lo_d)));
endmodule

bind timing_pi_filter timing_pi_checker #(.INT_W(INT_W), .OUT_W(OUT_W), .RD_W(RD_W)) u_chk (
  .clk(clk), .rst(rst), .err_valid(err_valid), .int_clear(int_clear),
  .int_wr(int_wr), .int_wdata(int_wdata), .lim_sel(lim_sel),
  .int_rdata(int_rdata), .ctrl_out(ctrl_out), .int_value(int_value)
);

// File: tb/sim_timing_pi_filter.sv
`timescale 1ns/1ps
module sim_timing_pi_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        err_valid = 1'b0;
  logic [11:0] err_in = '0;
  logic [7:0]  alpha = '0;
  logic [7:0]  beta_code = '0;
  logic [2:0]  lim_sel = '0;
  logic        int_clear = 1'b0;
  logic        int_wr = 1'b0;
  logic [7:0]  int_wdata = '0;
  logic [7:0]  int_rdata;
  logic [15:0] ctrl_out;

  int     n_tests = 0;
  int     n_fail  = 0;
  bit     done    = 0;
  longint m_acc   = 0;
  longint m_out   = 0;

  always #10 clk = ~clk;

  timing_pi_filter u0 (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_in(err_in),
    .alpha(alpha), .beta_code(beta_code), .lim_sel(lim_sel),
    .int_clear(int_clear), .int_wr(int_wr), .int_wdata(int_wdata),
    .int_rdata(int_rdata), .ctrl_out(ctrl_out)
  );

  function automatic int width_of(input int s);
    case (s)
      0: return 8;  1: return 10; 2: return 12; 3: return 14;
      4: return 16; 5: return 17; 6: return 18; default: return 20;
    endcase
  endfunction

  function automatic longint clamp(input longint v, input int w);
    longint hi = (64'sd1 <<< (w - 1)) - 1;
    longint lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint exp_rd();
    int w = width_of(int'(lim_sel));
    return (m_acc >>> (w - 8)) & 64'd255;
  endfunction

  // drive at the falling edge, model the rising edge, compare at the next falling edge
  task automatic step(input bit v, input int e, input bit clr, input bit wr, input int wd, input string tag);
    int     w;
    longint sw, pr;
    err_valid = v; err_in = 12'(e); int_clear = clr; int_wr = wr; int_wdata = 8'(wd);
    @(posedge clk);
    w  = width_of(int'(lim_sel));
    sw = (wd > 127) ? longint'(wd) - 256 : longint'(wd);
    if (clr)    m_acc = 0;
    else if (wr) m_acc = sw <<< (w - 8);
    else if (v) m_acc = clamp(m_acc + longint'(e) * longint'(beta_code[4:0]) * (64'sd1 <<< beta_code[7:5]), w);
    if (v) begin
      pr    = (longint'(e) * longint'(alpha)) >>> 4;
      m_out = clamp(m_acc + pr, 16);
    end
    @(negedge clk);
    err_valid = 0; int_clear = 0; int_wr = 0;
    chk(tag, "ctrl_out", longint'($signed(ctrl_out)), m_out);
    chk(tag, "int_rdata", longint'(int_rdata), exp_rd());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int errs[6];
    int alphas[5];
    errs   = '{-2048, -1, 0, 1, 100, 2047};
    alphas = '{0, 1, 15, 128, 255};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "ctrl_out", longint'($signed(ctrl_out)), 0);
    chk("R1", "int_rdata", longint'(int_rdata), 0);

    // R2: proportional path alone (clear holds the integrator at zero)
    lim_sel = 3'd7; beta_code = 8'h00;
    foreach (alphas[i]) foreach (errs[j]) begin
      alpha = 8'(alphas[i]);
      step(1, errs[j], 1, 0, 0, "R2");
    end

    // R3: mantissa/exponent sweep with accumulation
    alpha = 8'd3;
    for (int x = 0; x < 8; x++) begin
      for (int mi = 0; mi < 3; mi++) begin
        int m = (mi == 0) ? 1 : (mi == 1) ? 7 : 31;
        beta_code = 8'((x << 5) | m);
        step(0, 0, 1, 0, 0, "R3");
        step(1, 5, 0, 0, 0, "R3");
        step(1, -3, 0, 0, 0, "R3");
        step(1, 1, 0, 0, 0, "R3");
      end
    end

    // R4/R5: saturation rails at every width code
    beta_code = 8'hFF; alpha = 8'd0;
    for (int s = 0; s < 8; s++) begin
      lim_sel = 3'(s);
      step(0, 0, 1, 0, 0, "R4");
      step(1, 2047, 0, 0, 0, "R4");
      step(1, 2047, 0, 0, 0, "R4");
      chk("R5", "pos rail byte", longint'(int_rdata), 127);
      step(1, -2048, 0, 0, 0, "R4");
      step(1, -2048, 0, 0, 0, "R4");
      chk("R5", "neg rail byte", longint'(int_rdata), 128);
    end

    // R9: output saturation
    lim_sel = 3'd7; alpha = 8'd255;
    step(1, 2047, 0, 0, 0, "R9");
    step(1, 2047, 0, 0, 0, "R9");
    chk("R9", "pos sat", longint'($signed(ctrl_out)), 32767);
    step(1, -2048, 0, 0, 0, "R9");
    step(1, -2048, 0, 0, 0, "R9");
    chk("R9", "neg sat", longint'($signed(ctrl_out)), -32768);

    // R6: top byte load clears lower bits, beats accumulation
    beta_code = 8'h21; alpha = 8'd16;
    for (int s = 0; s < 8; s++) begin
      int wds[6];
      wds = '{0, 1, 127, 128, 255, 85};
      lim_sel = 3'(s);
      foreach (wds[k]) begin
        step(1, 3, 0, 0, 0, "R6");
        step(1, 7, 0, 1, wds[k], "R6");
        chk("R6", "readback", longint'(int_rdata), longint'(wds[k]));
        step(1, 1, 0, 0, 0, "R6");
      end
    end

    // R7: clear beats write and accumulation
    lim_sel = 3'd4;
    step(1, 100, 0, 0, 0, "R7");
    step(1, 100, 1, 1, 8'h55, "R7");
    chk("R7", "cleared byte", longint'(int_rdata), 0);
    step(0, 0, 1, 1, 8'h7F, "R7");

    // R8: idle cycles hold everything
    step(1, 900, 0, 0, 0, "R8");
    alpha = 8'd200; beta_code = 8'hE7;
    step(0, -1000, 0, 0, 0, "R8");
    step(0, 2047, 0, 0, 0, "R8");
    alpha = 8'd5;
    step(0, 12, 0, 0, 0, "R8");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule